// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a first-level cache placed between a core port and a slower RAM port. Both ports use the same three-signal handshake. A request is taken when `valid` and `ready` are both high at a clock edge. Read data comes back with a `good` strobe that lasts exactly one cycle. The cache holds one request at a time. Each request moves one whole 64-bit block.

The cache is organised as 8 sets of 4 ways, which gives 32 entries. Each entry has a metadata record with these fields:
- a valid flag
- a dirty flag
- a tag
- a pointer into a separate block-data array
- an age stamp holding the value of a free-running cycle counter at the last access to that block

Least-recently-accessed replacement follows directly from comparing the age stamps. Writes stay in the cache until the modified block is chosen as a victim. The cache then refills the block and writes the old contents to RAM. It answers the core as soon as RAM has accepted that write, without waiting for the write to finish.

Setting `WRITABLE` to 0 gives the instruction-side variant. In that variant every request is served as a read.

Top module: `wb_assoc_cache`

## Requirements
- R1: A read that hits returns the stored block with `core_resp_good_o` high for one cycle, in the second cycle after the accepting edge, and issues no RAM request.
- R2: The address splits into byte offset [2:0] (ignored), set [5:3] and tag [31:6]. A read miss issues one RAM read at the block address {tag, set, 000}, returns the RAM data and installs the block, so the next access to that block hits.
- R3: A write replaces the whole block and its response carries the written block. A write miss first fills the block, then overwrites it and marks it dirty. Later reads return the written value.
- R4: A write hit leaves RAM untouched. The new data reaches RAM only when the block is evicted.
- R5: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way with the smallest age stamp, and ties go to the lowest way. A hit or a fill sets the entry's stamp to the current cycle count.
- R6: A dirty victim is written to RAM at its own block address, carrying its latest data. A clean victim never causes a RAM write.
- R7: On a miss with a dirty victim, the core response appears in the cycle right after RAM accepts the eviction write. A RAM request stays asserted, with a stable address, until it is accepted. A later miss waits for `mem_req_ready_i` before issuing its fill.
- R8: Four counters count read hits, read misses, write hits and write misses. Each counter rises by one per lookup of its kind.
- R9: With `WRITABLE`=0, a write request is served as a read. It returns the stored block, leaves the block unchanged and never produces a RAM write.
- R10: `core_req_ready_o` is low from the accepting edge until the response has been given.
- R11: After reset, all entries are invalid and all counters are zero. `core_req_ready_o` is high, and `core_resp_good_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| core_req_valid_i | input | 1 | Core request present |
| core_req_ready_o | output | 1 | Cache can take a request |
| core_req_addr_i | input | ADDR_W | Byte address of the request |
| core_req_write_i | input | 1 | 1 = write, 0 = read |
| core_req_wdata_i | input | 8*BLOCK_BYTES | Block to write |
| core_resp_good_o | output | 1 | One-cycle response strobe |
| core_resp_rdata_o | output | 8*BLOCK_BYTES | Response block |
| mem_req_valid_o | output | 1 | RAM request present |
| mem_req_ready_i | input | 1 | RAM can take a request |
| mem_req_addr_o | output | ADDR_W | Block-aligned RAM address |
| mem_req_write_o | output | 1 | 1 = eviction write, 0 = fill read |
| mem_req_wdata_o | output | 8*BLOCK_BYTES | Eviction data |
| mem_resp_good_i | input | 1 | Fill data valid strobe |
| mem_resp_rdata_i | input | 8*BLOCK_BYTES | Fill data |
| rd_hit_cnt_o | output | CNT_W | Read hits |
| rd_miss_cnt_o | output | CNT_W | Read misses |
| wr_hit_cnt_o | output | CNT_W | Write hits |
| wr_miss_cnt_o | output | CNT_W | Write misses |

## Verification
Different internal faults show up at the ports in different ways, and usually within one access:
- A corrupted tag or valid bit turns a 2-cycle hit into a miss of more than 30 cycles, or the reverse. This is visible in the latency of the same access, and it also bumps the RAM read count.
- A wrong age stamp or a bad victim choice does not show at once. It surfaces a few accesses later, when a block that should still be resident misses, or one that should be gone hits.
- A lost dirty flag or a wrong data pointer appears only after an eviction. Either the RAM copy at the victim address is stale, or a later refill returns a block that differs from the bench's shadow memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_EVICT
  } wbc_state_e;

endpackage

// File: rtl/wbc_hit_detect.sv
module wbc_hit_detect #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           look_tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);

  logic [WAYS-1:0] match;

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == look_tag_i);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit_o) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 32,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0] age_i,
  output logic [WAY_W-1:0]           victim_o
);

  logic             free_found;
  logic [AGE_W-1:0] oldest;

  always_comb begin
    free_found = 1'b0;
    victim_o   = '0;
    oldest     = age_i[0];
    // an empty way wins, lowest index first
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !free_found) begin
        free_found = 1'b1;
        victim_o   = WAY_W'(w);
      end
    end
    // otherwise the oldest stamp; strict compare keeps ties on the lower way
    if (!free_found) begin
      for (int w = 1; w < WAYS; w++) begin
        if (age_i[w] < oldest) begin
          oldest   = age_i[w];
          victim_o = WAY_W'(w);
        end
      end
    end
  end

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int DEPTH   = 32,
  parameter int PTR_W   = 5,
  parameter int BLOCK_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [PTR_W-1:0]   widx_i,
  input  logic [BLOCK_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]   ridx_a_i,
  output logic [BLOCK_W-1:0] rdata_a_o,
  input  logic [PTR_W-1:0]   ridx_b_i,
  output logic [BLOCK_W-1:0] rdata_b_o
);

  logic [BLOCK_W-1:0] blk_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) blk_q[e] <= '0;
    end else if (we_i) begin
      blk_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = blk_q[ridx_a_i];
  assign rdata_b_o = blk_q[ridx_b_i];

endmodule

// File: rtl/wb_assoc_cache.sv
module wb_assoc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 8,
  parameter int SETS        = 8,
  parameter int WAYS        = 4,
  parameter int AGE_W       = 32,
  parameter int CNT_W       = 16,
  parameter bit WRITABLE    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_req_valid_i,
  output logic                     core_req_ready_o,
  input  logic [ADDR_W-1:0]        core_req_addr_i,
  input  logic                     core_req_write_i,
  input  logic [8*BLOCK_BYTES-1:0] core_req_wdata_i,
  output logic                     core_resp_good_o,
  output logic [8*BLOCK_BYTES-1:0] core_resp_rdata_o,
  output logic                     mem_req_valid_o,
  input  logic                     mem_req_ready_i,
  output logic [ADDR_W-1:0]        mem_req_addr_o,
  output logic                     mem_req_write_o,
  output logic [8*BLOCK_BYTES-1:0] mem_req_wdata_o,
  input  logic                     mem_resp_good_i,
  input  logic [8*BLOCK_BYTES-1:0] mem_resp_rdata_i,
  output logic [CNT_W-1:0]         rd_hit_cnt_o,
  output logic [CNT_W-1:0]         rd_miss_cnt_o,
  output logic [CNT_W-1:0]         wr_hit_cnt_o,
  output logic [CNT_W-1:0]         wr_miss_cnt_o
);

  localparam int BLOCK_W = 8 * BLOCK_BYTES;
  localparam int OFS_W   = $clog2(BLOCK_BYTES);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int PTR_W   = $clog2(ENTRIES);
  localparam int BLK_W   = ADDR_W - OFS_W;
  localparam int TAG_W   = BLK_W - SET_W;

  // reset: asserted at once, released two edges later
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // metadata table
  logic [SETS-1:0][WAYS-1:0]            valid_q, dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][PTR_W-1:0] ptr_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  wbc_state_e         state_q, state_d;
  logic [BLK_W-1:0]   req_blk_q;
  logic               req_write_q;
  logic [BLOCK_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]   vic_way_q;
  logic               vic_dirty_q;
  logic [TAG_W-1:0]   vic_tag_q;
  logic [BLOCK_W-1:0] wb_data_q;
  logic               resp_good_q, resp_good_d;
  logic [BLOCK_W-1:0] resp_rdata_q, resp_rdata_d;
  logic [AGE_W-1:0]   cyc_q;
  logic [CNT_W-1:0]   rd_hit_q, rd_miss_q, wr_hit_q, wr_miss_q;

  logic [SET_W-1:0]   set_idx;
  logic [TAG_W-1:0]   tag_cur;
  logic               is_write;
  logic               accept;
  logic               hit;
  logic [WAY_W-1:0]   hit_way, vic_way;
  logic [BLOCK_W-1:0] rd_a, rd_b;

  // next-state controls
  logic               meta_we, meta_dirty;
  logic [WAY_W-1:0]   meta_way;
  logic               dat_we;
  logic [PTR_W-1:0]   dat_idx;
  logic [BLOCK_W-1:0] dat_wdata;
  logic               cap_victim;
  logic               inc_rh, inc_rm, inc_wh, inc_wm;

  assign set_idx  = req_blk_q[SET_W-1:0];
  assign tag_cur  = req_blk_q[BLK_W-1 -: TAG_W];
  assign is_write = req_write_q && WRITABLE;
  assign core_req_ready_o = (state_q == ST_IDLE) && rst_int_n;
  assign accept   = core_req_valid_i && core_req_ready_o;

  wbc_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_hit (
    .valid_i    (valid_q[set_idx]),
    .tags_i     (tag_q[set_idx]),
    .look_tag_i (tag_cur),
    .hit_o      (hit),
    .hit_way_o  (hit_way)
  );

  wbc_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_vic (
    .valid_i  (valid_q[set_idx]),
    .age_i    (age_q[set_idx]),
    .victim_o (vic_way)
  );

  wbc_data_store #(.DEPTH(ENTRIES), .PTR_W(PTR_W), .BLOCK_W(BLOCK_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we_i      (dat_we),
    .widx_i    (dat_idx),
    .wdata_i   (dat_wdata),
    .ridx_a_i  (ptr_q[set_idx][hit_way]),
    .rdata_a_o (rd_a),
    .ridx_b_i  (ptr_q[set_idx][vic_way]),
    .rdata_b_o (rd_b)
  );

  always_comb begin
    state_d         = state_q;
    meta_we         = 1'b0;
    meta_way        = '0;
    meta_dirty      = 1'b0;
    dat_we          = 1'b0;
    dat_idx         = '0;
    dat_wdata       = req_wdata_q;
    cap_victim      = 1'b0;
    resp_good_d     = 1'b0;
    resp_rdata_d    = resp_rdata_q;
    inc_rh          = 1'b0;
    inc_rm          = 1'b0;
    inc_wh          = 1'b0;
    inc_wm          = 1'b0;
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = {req_blk_q, {OFS_W{1'b0}}};
    mem_req_wdata_o = wb_data_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit) begin
          meta_we      = 1'b1;
          meta_way     = hit_way;
          meta_dirty   = dirty_q[set_idx][hit_way] | is_write;
          dat_we       = is_write;
          dat_idx      = ptr_q[set_idx][hit_way];
          resp_good_d  = 1'b1;
          resp_rdata_d = is_write ? req_wdata_q : rd_a;
          inc_wh       = is_write;
          inc_rh       = !is_write;
          state_d      = ST_IDLE;
        end else begin
          cap_victim = 1'b1;
          inc_wm     = is_write;
          inc_rm     = !is_write;
          state_d    = ST_FILL_REQ;
        end
      end
      ST_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_resp_good_i) begin
          meta_we      = 1'b1;
          meta_way     = vic_way_q;
          meta_dirty   = is_write;
          dat_we       = 1'b1;
          dat_idx      = ptr_q[set_idx][vic_way_q];
          dat_wdata    = is_write ? req_wdata_q : mem_resp_rdata_i;
          resp_rdata_d = dat_wdata;
          if (vic_dirty_q) begin
            state_d = ST_EVICT;
          end else begin
            resp_good_d = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_EVICT: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = {vic_tag_q, set_idx, {OFS_W{1'b0}}};
        if (mem_req_ready_i) begin
          resp_good_d = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q      <= ST_IDLE;
      resp_good_q  <= 1'b0;
      resp_rdata_q <= '0;
      cyc_q        <= '0;
    end else begin
      state_q      <= state_d;
      resp_good_q  <= resp_good_d;
      resp_rdata_q <= resp_rdata_d;
      cyc_q        <= cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_blk_q   <= '0;
      req_write_q <= 1'b0;
      req_wdata_q <= '0;
    end else if (accept) begin
      req_blk_q   <= core_req_addr_i[ADDR_W-1:OFS_W];
      req_write_q <= core_req_write_i;
      req_wdata_q <= core_req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vic_way_q   <= '0;
      vic_dirty_q <= 1'b0;
      vic_tag_q   <= '0;
      wb_data_q   <= '0;
    end else if (cap_victim) begin
      vic_way_q   <= vic_way;
      vic_dirty_q <= valid_q[set_idx][vic_way] && dirty_q[set_idx][vic_way];
      vic_tag_q   <= tag_q[set_idx][vic_way];
      wb_data_q   <= rd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          ptr_q[s][w]   <= PTR_W'(s * WAYS + w);
          age_q[s][w]   <= '0;
        end
      end
    end else if (meta_we) begin
      valid_q[set_idx][meta_way] <= 1'b1;
      dirty_q[set_idx][meta_way] <= meta_dirty;
      tag_q[set_idx][meta_way]   <= tag_cur;
      age_q[set_idx][meta_way]   <= cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_hit_q  <= '0;
      rd_miss_q <= '0;
      wr_hit_q  <= '0;
      wr_miss_q <= '0;
    end else begin
      if (inc_rh) rd_hit_q  <= rd_hit_q + 1'b1;
      if (inc_rm) rd_miss_q <= rd_miss_q + 1'b1;
      if (inc_wh) wr_hit_q  <= wr_hit_q + 1'b1;
      if (inc_wm) wr_miss_q <= wr_miss_q + 1'b1;
    end
  end

  assign core_resp_good_o  = resp_good_q;
  assign core_resp_rdata_o = resp_rdata_q;
  assign rd_hit_cnt_o      = rd_hit_q;
  assign rd_miss_cnt_o     = rd_miss_q;
  assign wr_hit_cnt_o      = wr_hit_q;
  assign wr_miss_cnt_o     = wr_miss_q;

  AST_GOOD_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_resp_good_o |=> !core_resp_good_o); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_req_valid_i && core_req_ready_o |=> !core_req_ready_o); // R10

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)); // R7

  AST_EVICT_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid_o && mem_req_ready_i && mem_req_write_o |=> core_resp_good_o); // R7

  AST_HITCNT_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_hit_cnt_o != $past(rd_hit_cnt_o)) |-> core_resp_good_o); // R8

  if (!WRITABLE) begin : g_ro_chk
    AST_RO_NO_MEMWRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
      !(mem_req_valid_o && mem_req_write_o)); // R9
  end

endmodule

// File: tb/wb_assoc_cache_tb.sv
`timescale 1ns/1ps

module tb_ram #(
  parameter int LAT    = 30,
  parameter int BLOCKS = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [63:0] req_wdata,
  output logic        resp_good,
  output logic [63:0] resp_rdata,
  output logic        wr_pulse,
  output int          wr_count,
  output int          rd_count
);
  logic [63:0] mem [BLOCKS];
  logic        busy, pend_rd;
  int          cnt, pend;

  function automatic logic [63:0] seed_val(int b);
    return {16'hC0DE, 16'(b), 32'(b * 32'h9E3779B1)};
  endfunction

  initial for (int i = 0; i < BLOCKS; i++) mem[i] = seed_val(i);

  assign req_ready = !busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; cnt <= 0; pend <= 0; pend_rd <= 0;
      resp_good <= 0; resp_rdata <= '0; wr_pulse <= 0;
      wr_count <= 0; rd_count <= 0;
    end else begin
      resp_good <= 0;
      wr_pulse  <= 0;
      if (req_valid && !busy) begin
        busy    <= 1;
        cnt     <= LAT;
        pend    <= int'(req_addr[11:3]);
        pend_rd <= !req_write;
        if (req_write) begin
          mem[req_addr[11:3]] <= req_wdata;
          wr_pulse <= 1;
          wr_count <= wr_count + 1;
        end else begin
          rd_count <= rd_count + 1;
        end
      end else if (busy) begin
        if (cnt > 1) cnt <= cnt - 1;
        else begin
          busy <= 0;
          if (pend_rd) begin
            resp_good  <= 1;
            resp_rdata <= mem[pend];
          end
        end
      end
    end
  end
endmodule

module wb_assoc_cache_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  // writable instance
  logic        c_valid = 0, c_ready, c_we = 0, c_good;
  logic [31:0] c_addr = '0;
  logic [63:0] c_wdata = '0, c_rdata;
  logic        m_valid, m_ready, m_we, m_good;
  logic [31:0] m_addr;
  logic [63:0] m_wdata, m_rdata;
  logic [15:0] n_rh, n_rm, n_wh, n_wm;
  logic        m_wp;
  int          m_wc, m_rc;

  // read-only instance
  logic        r_valid = 0, r_ready, r_we = 0, r_good;
  logic [31:0] r_addr = '0;
  logic [63:0] r_wdata = '0, r_rdata;
  logic        rm_valid, rm_ready, rm_we, rm_good;
  logic [31:0] rm_addr;
  logic [63:0] rm_wdata, rm_rdata;
  logic [15:0] r_rh, r_rm, r_wh, r_wm;
  logic        rm_wp;
  int          rm_wc, rm_rc;

  wb_assoc_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid_i(c_valid), .core_req_ready_o(c_ready), .core_req_addr_i(c_addr),
    .core_req_write_i(c_we), .core_req_wdata_i(c_wdata),
    .core_resp_good_o(c_good), .core_resp_rdata_o(c_rdata),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_req_addr_o(m_addr),
    .mem_req_write_o(m_we), .mem_req_wdata_o(m_wdata),
    .mem_resp_good_i(m_good), .mem_resp_rdata_i(m_rdata),
    .rd_hit_cnt_o(n_rh), .rd_miss_cnt_o(n_rm), .wr_hit_cnt_o(n_wh), .wr_miss_cnt_o(n_wm)
  );

  tb_ram u_ram (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid), .req_ready(m_ready), .req_addr(m_addr),
    .req_write(m_we), .req_wdata(m_wdata), .resp_good(m_good), .resp_rdata(m_rdata),
    .wr_pulse(m_wp), .wr_count(m_wc), .rd_count(m_rc)
  );

  wb_assoc_cache #(.WRITABLE(1'b0)) u_dut_ro (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid_i(r_valid), .core_req_ready_o(r_ready), .core_req_addr_i(r_addr),
    .core_req_write_i(r_we), .core_req_wdata_i(r_wdata),
    .core_resp_good_o(r_good), .core_resp_rdata_o(r_rdata),
    .mem_req_valid_o(rm_valid), .mem_req_ready_i(rm_ready), .mem_req_addr_o(rm_addr),
    .mem_req_write_o(rm_we), .mem_req_wdata_o(rm_wdata),
    .mem_resp_good_i(rm_good), .mem_resp_rdata_i(rm_rdata),
    .rd_hit_cnt_o(r_rh), .rd_miss_cnt_o(r_rm), .wr_hit_cnt_o(r_wh), .wr_miss_cnt_o(r_wm)
  );

  tb_ram u_ram_ro (
    .clk(clk), .rst_n(rst_n), .req_valid(rm_valid), .req_ready(rm_ready), .req_addr(rm_addr),
    .req_write(rm_we), .req_wdata(rm_wdata), .resp_good(rm_good), .resp_rdata(rm_rdata),
    .wr_pulse(rm_wp), .wr_count(rm_wc), .rd_count(rm_rc)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // shadow memory and replacement model
  logic [63:0] gold [512];
  bit mv [8][4];
  bit md [8][4];
  int mt [8][4];
  int ms [8][4];
  int stamp = 0;

  function automatic logic [63:0] seed_val(int b);
    return {16'hC0DE, 16'(b), 32'(b * 32'h9E3779B1)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // R5 model: empty way first, else oldest access, ties lowest way
  task automatic model(input logic [31:0] a, input bit we, output bit hit, output bit ev, output int ev_blk);
    int s, t, v;
    s = int'(a[5:3]); t = int'(a[31:6]); v = -1;
    hit = 0; ev = 0; ev_blk = 0;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) begin hit = 1; v = w; end
    if (!hit) begin
      for (int w = 0; w < 4; w++) if (!mv[s][w] && v < 0) v = w;
      if (v < 0) begin
        v = 0;
        for (int w = 1; w < 4; w++) if (ms[s][w] < ms[s][v]) v = w;
      end
      ev = md[s][v];
      ev_blk = (mt[s][v] << 3) | s;
      mv[s][v] = 1; mt[s][v] = t; md[s][v] = 0;
    end
    stamp++;
    ms[s][v] = stamp;
    if (we) md[s][v] = 1;
  endtask

  task automatic do_access(input logic [31:0] a, input bit we, input logic [63:0] wd,
                           output logic [63:0] rd, output int lat, output bit rdy1, output bit wp);
    while (!c_ready) @(negedge clk);
    c_valid = 1; c_addr = a; c_we = we; c_wdata = wd;
    @(negedge clk);
    c_valid = 0; rdy1 = c_ready; lat = 1;
    while (!c_good && lat < 3000) begin @(negedge clk); lat++; end
    rd = c_rdata; wp = m_wp;
  endtask

  task automatic run(input logic [31:0] a, input bit we, input logic [63:0] wd);
    bit hit, ev, rdy1, wp;
    int ev_blk, blk, lat, rc0, wc0;
    logic [63:0] rd, exp, ram_before;
    logic [15:0] rh0, rm0, wh0, wm0;
    blk = int'(a[11:3]);
    exp = gold[blk];
    model(a, we, hit, ev, ev_blk);
    rc0 = m_rc; wc0 = m_wc; rh0 = n_rh; rm0 = n_rm; wh0 = n_wh; wm0 = n_wm;
    ram_before = u_ram.mem[blk];
    do_access(a, we, wd, rd, lat, rdy1, wp);
    chk(lat < 3000, "R7 response arrives", 64'(lat), 64'(3000));
    chk(rdy1 == 0, "R10 ready low while busy", 64'(rdy1), 64'(0));
    if (we) chk(rd == wd, "R3 write response data", rd, wd);
    else if (hit) chk(rd == exp, "R1 hit data", rd, exp);
    else chk(rd == exp, "R2 miss data", rd, exp);
    if (hit) begin
      chk(lat == 2, "R1 hit latency (R5 prediction)", 64'(lat), 64'(2));
      chk(m_rc == rc0 && m_wc == wc0, "R1 hit makes no RAM access", 64'(m_rc + m_wc), 64'(rc0 + wc0));
      if (we) chk(u_ram.mem[blk] == ram_before, "R4 write hit leaves RAM", u_ram.mem[blk], ram_before);
    end else begin
      chk(lat >= 33, "R5 miss latency (replacement prediction)", 64'(lat), 64'(33));
      chk(m_rc == rc0 + 1, "R2 one fill read", 64'(m_rc), 64'(rc0 + 1));
      chk(m_wc == wc0 + int'(ev), "R6 eviction write count", 64'(m_wc), 64'(wc0 + int'(ev)));
      if (ev) begin
        chk(u_ram.mem[ev_blk] == gold[ev_blk], "R6 evicted data", u_ram.mem[ev_blk], gold[ev_blk]);
        chk(wp == 1, "R7 response follows eviction accept", 64'(wp), 64'(1));
      end
    end
    chk(n_rh == rh0 + 16'(hit && !we), "R8 read hit count", 64'(n_rh), 64'(rh0 + 16'(hit && !we)));
    chk(n_rm == rm0 + 16'(!hit && !we), "R8 read miss count", 64'(n_rm), 64'(rm0 + 16'(!hit && !we)));
    chk(n_wh == wh0 + 16'(hit && we), "R8 write hit count", 64'(n_wh), 64'(wh0 + 16'(hit && we)));
    chk(n_wm == wm0 + 16'(!hit && we), "R8 write miss count", 64'(n_wm), 64'(wm0 + 16'(!hit && we)));
    if (we) gold[blk] = wd;
  endtask

  task automatic ro_access(input logic [31:0] a, input bit we, input logic [63:0] wd,
                           output logic [63:0] rd, output int lat);
    while (!r_ready) @(negedge clk);
    r_valid = 1; r_addr = a; r_we = we; r_wdata = wd;
    @(negedge clk);
    r_valid = 0; lat = 1;
    while (!r_good && lat < 3000) begin @(negedge clk); lat++; end
    rd = r_rdata;
  endtask

  initial begin
    logic [63:0] rd;
    int lat;
    for (int i = 0; i < 512; i++) gold[i] = seed_val(i);
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(c_ready == 1, "R11 ready after reset", 64'(c_ready), 64'(1));
    chk(c_good == 0, "R11 no response after reset", 64'(c_good), 64'(0));
    chk(m_valid == 0, "R11 no RAM request after reset", 64'(m_valid), 64'(0));
    chk({n_rh, n_rm, n_wh, n_wm} == '0, "R11 counters zero", 64'({n_rh, n_rm, n_wh, n_wm}), 64'(0));

    // R2 then R1: fill, hit, hit with other offset bits
    run(32'h40, 0, '0);
    run(32'h40, 0, '0);
    run(32'h45, 0, '0);
    // R3 R4: write hit, read back
    run(32'h43, 1, 64'h1111_2222_3333_4444);
    run(32'h40, 0, '0);
    // R3 write miss allocates
    run(32'h88, 1, 64'hABCD_0000_0000_0088);
    run(32'h88, 0, '0);
    // R5 LRU order in set 2
    for (int t = 0; t < 4; t++) run(32'((t << 6) | (2 << 3)), 0, '0);
    run(32'((0 << 6) | (2 << 3)), 0, '0);
    run(32'((4 << 6) | (2 << 3)), 0, '0);   // evicts tag 1
    run(32'((0 << 6) | (2 << 3)), 0, '0);   // still hits
    run(32'((1 << 6) | (2 << 3)), 0, '0);   // misses
    // R6 R7 dirty eviction in set 3 then back-to-back misses
    run(32'((0 << 6) | (3 << 3)), 1, 64'hDEAD_BEEF_0000_0003);
    for (int t = 1; t < 6; t++) run(32'((t << 6) | (3 << 3)), 0, '0);
    run(32'((0 << 6) | (3 << 3)), 0, '0);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      bit we;
      a  = {22'd0, 4'($urandom % 16), 3'($urandom % 8), 3'($urandom % 8)};
      we = ($urandom % 3) == 0;
      run(a, we, {$urandom, $urandom});
    end

    // R9 read-only variant
    ro_access(32'h40, 0, '0, rd, lat);
    chk(rd == seed_val(8), "R9 ro fill data", rd, seed_val(8));
    ro_access(32'h40, 1, 64'h5555_6666_7777_8888, rd, lat);
    chk(rd == seed_val(8), "R9 ro write returns stored block", rd, seed_val(8));
    chk(lat == 2, "R9 ro write served as hit", 64'(lat), 64'(2));
    ro_access(32'h40, 0, '0, rd, lat);
    chk(rd == seed_val(8), "R9 ro block unchanged", rd, seed_val(8));
    chk(r_wh == 0 && r_wm == 0, "R9 ro no write lookups", 64'({r_wh, r_wm}), 64'(0));
    for (int t = 2; t < 7; t++) ro_access(32'(t << 6), 0, '0, rd, lat);
    ro_access(32'h40, 0, '0, rd, lat);
    chk(rd == seed_val(8), "R9 ro refill unchanged", rd, seed_val(8));
    repeat (40) @(negedge clk);
    chk(rm_wc == 0, "R9 ro never writes RAM", 64'(rm_wc), 64'(0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule